// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel with a byte-wide register port. The port has two addresses: a control address that takes an eight-bit command, and a data address through which software loads the initial count and reads the count back. A command picks one of three counting behaviours and one of four byte-access schemes. The schemes are a snapshot command, low byte only, high byte only, and low-then-high. Counting advances on each rising edge of a separate count-enable input that is sampled in the system clock domain. The registered output `tmr_out` carries the expiry indication.

There are three behaviours. The terminal-count behaviour drives `tmr_out` low when a count is loaded and high once it expires. The rate-generator behaviour reloads itself and gives an active-low pulse of one count period on every pass. The strobe behaviour gives a single active-low pulse of one count period for each count written. Software can freeze a copy of the running count and read it back byte by byte while counting goes on.

Top module: `ivt_chan`

## Requirements
- R1: After synchronous reset `tmr_out` is 0 and `bus_rdata` is 0. The counter holds 0 and is stopped, the behaviour is terminal-count and the access scheme is low-then-high.
- R2: A control word is decoded as follows. Bits 7:6 are the channel and must be 00. Bits 5:4 are the access field: 00 snapshot, 01 low only, 10 high only, 11 low-then-high. Bits 3:1 are the behaviour code: 000 terminal-count, 010 or 110 rate generator, 100 strobe. Bit 0 must be 0. With a nonzero access field, any other word is ignored: behaviour, output, byte pointers and counting are left unchanged. That covers a nonzero channel, bit 0 set, and the codes 001, 011, 101 and 111.
- R3: An accepted non-snapshot control word stops the counter and returns both byte pointers to the low byte. It discards a held snapshot. It sets `tmr_out` to 0 for terminal-count and to 1 for the other two behaviours.
- R4: In low-then-high access a count is written as a low byte and then a high byte to data address 0. Counting starts only after the high byte. In terminal-count, the low-byte write stops the counter and drives `tmr_out` low.
- R5: In low-only access one write loads the byte with a high part of zero. In high-only access one write loads the byte as the high part with a low part of zero. High-byte bits above the count width are dropped. A read in these schemes returns the matching single byte.
- R6: A count of 0 stands for 2^CNT_W count-enable edges.
- R7: A running counter decrements once per rising edge of `cnt_en`. With no such edge and no bus write, the count does not change.
- R8: In terminal-count, `tmr_out` rises after exactly N edges from a load of N and then stays high until the next control or data write. Every new count rearms the counter, including after a stop and including a count of zero.
- R9: In the rate generator, `tmr_out` is low for one count period while the count is 1 and then the programmed count reloads. This gives one low period every N edges with no further writes.
- R10: In the rate generator, a count written while the counter runs takes effect at the next reload and does not disturb the current pass.
- R11: In strobe, `tmr_out` stays high and goes low for one count period when the count reaches 0 after N edges. The counter keeps wrapping with no further pulse until a new count is written, which schedules exactly one more pulse.
- R12: A control word with access field 00 and channel 00 copies the current count into a snapshot and leaves behaviour and output unchanged. Reads return the snapshot until the access sequence completes: both bytes in low-then-high access, or one byte otherwise. A further snapshot command while one is held is ignored.
- R13: Data reads with no snapshot held return the live count, low byte first in low-then-high access. A read of the control address returns 0. The byte appears on `bus_rdata` in the cycle after the read strobe and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte; ignored while `bus_wr` is high |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| cnt_en | input | 1 | Count-enable; each rising edge is one count |
| tmr_out | output | 1 | Registered timer output |

## Verification
The bench builds the channel with `CNT_W` = 10. At that width a count of zero needs only 1024 edges, so the full-range expiry and the wrap after terminal count both fit in a short run. The high byte is then only two bits wide, which exposes the dropping of upper write bits and the zero padding of the read byte. For every behaviour the bench sweeps counts from 1 upward and a few values near byte boundaries. It computes the expected output edge by edge from the period arithmetic, and it reads snapshots back to compare against the count of edges applied.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    MD_TC     = 2'd0,
    MD_RATE   = 2'd1,
    MD_STROBE = 2'd2
  } ivt_mode_e;

  typedef enum logic [1:0] {
    AC_SNAP = 2'b00,
    AC_LO   = 2'b01,
    AC_HI   = 2'b10,
    AC_BOTH = 2'b11
  } ivt_acc_e;

  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] acc;
    logic [2:0] mcode;
    logic       bcd;
  } ivt_cw_t;

  function automatic logic mcode_ok(input logic [2:0] m);
    return (m == 3'b000) || (m == 3'b100) || (m[1:0] == 2'b10);
  endfunction

  function automatic ivt_mode_e mcode_to_mode(input logic [2:0] m);
    if (m == 3'b100) return MD_STROBE;
    if (m[1:0] == 2'b10) return MD_RATE;
    return MD_TC;
  endfunction

endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [BUS_W-1:0] wdata,
  output ivt_mode_e        mode_q,
  output ivt_mode_e        new_mode,
  output ivt_acc_e         acc_q,
  output logic             mode_set,
  output logic             snap_cmd
);

  ivt_cw_t cw;
  logic    chan_hit;

  assign cw       = ivt_cw_t'(wdata);
  assign chan_hit = ctl_wr && (cw.chan == 2'b00);
  assign snap_cmd = chan_hit && (cw.acc == AC_SNAP);
  assign mode_set = chan_hit && (cw.acc != AC_SNAP) && !cw.bcd && mcode_ok(cw.mcode);
  assign new_mode = mcode_to_mode(cw.mcode);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_TC;
      acc_q  <= AC_BOTH;
    end else if (mode_set) begin
      mode_q <= new_mode;
      acc_q  <= ivt_acc_e'(cw.acc);
    end
  end

endmodule

// File: rtl/ivt_io.sv
module ivt_io
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ivt_acc_e         acc_q,
  input  logic             mode_set,
  input  logic             snap_cmd,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic             ctl_rd,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             load_stb,
  output logic             part_stb,
  output logic [CNT_W-1:0] load_val,
  output logic [BUS_W-1:0] rdata,
  output logic             latched_q,
  output logic [CNT_W-1:0] snap_q
);

  localparam int HI_W = CNT_W - BUS_W;

  logic             wr_hi_q;
  logic             rd_hi_q;
  logic [BUS_W-1:0] lo_buf_q;
  logic [CNT_W-1:0] view;
  logic [BUS_W-1:0] lo_byte;
  logic [BUS_W-1:0] hi_byte;
  logic             rd_done;

  assign view    = latched_q ? snap_q : cnt_q;
  assign lo_byte = view[BUS_W-1:0];

  generate
    if (HI_W == BUS_W) begin : g_hi_full
      assign hi_byte = view[CNT_W-1:BUS_W];
    end else begin : g_hi_pad
      assign hi_byte = {{(BUS_W-HI_W){1'b0}}, view[CNT_W-1:BUS_W]};
    end
  endgenerate

  // Count assembly from byte writes
  always_comb begin
    load_stb = 1'b0;
    part_stb = 1'b0;
    load_val = '0;
    if (dat_wr) begin
      case (acc_q)
        AC_LO: begin
          load_stb = 1'b1;
          load_val = {{HI_W{1'b0}}, wdata};
        end
        AC_HI: begin
          load_stb = 1'b1;
          load_val = {wdata[HI_W-1:0], {BUS_W{1'b0}}};
        end
        AC_BOTH: begin
          if (wr_hi_q) begin
            load_stb = 1'b1;
            load_val = {wdata[HI_W-1:0], lo_buf_q};
          end else begin
            part_stb = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_done = dat_rd && ((acc_q != AC_BOTH) || rd_hi_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      lo_buf_q  <= '0;
      latched_q <= 1'b0;
      snap_q    <= '0;
    end else if (mode_set) begin
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      if (dat_wr && (acc_q == AC_BOTH)) begin
        wr_hi_q <= !wr_hi_q;
        if (!wr_hi_q) lo_buf_q <= wdata;
      end
      if (dat_rd && (acc_q == AC_BOTH)) rd_hi_q <= !rd_hi_q;
      if (snap_cmd && !latched_q) begin
        latched_q <= 1'b1;
        snap_q    <= cnt_q;
      end else if (rd_done) begin
        latched_q <= 1'b0;
      end
    end
  end

  // Registered read byte
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (dat_rd) begin
      case (acc_q)
        AC_LO:   rdata <= lo_byte;
        AC_HI:   rdata <= hi_byte;
        default: rdata <= rd_hi_q ? hi_byte : lo_byte;
      endcase
    end else if (ctl_rd) begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/ivt_core.sv
module ivt_core
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  ivt_mode_e        mode_q,
  input  ivt_mode_e        new_mode,
  input  logic             mode_set,
  input  logic             load_stb,
  input  logic             part_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tmr_out
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             en_q;
  logic             run_q;
  logic             armed_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] dec;
  logic             step;
  logic             hit0;

  assign dec  = cnt_q - ONE;
  assign step = cnt_en && !en_q && run_q;
  assign hit0 = armed_q && (dec == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b1;
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      reload_q <= '0;
      tmr_out  <= 1'b0;
    end else begin
      en_q <= cnt_en;
      if (mode_set) begin
        run_q   <= 1'b0;
        armed_q <= 1'b0;
        tmr_out <= (new_mode != MD_TC);
      end else if (load_stb) begin
        reload_q <= load_val;
        if (!((mode_q == MD_RATE) && run_q)) begin
          cnt_q   <= load_val;
          run_q   <= 1'b1;
          armed_q <= 1'b1;
          tmr_out <= (mode_q != MD_TC);
        end
      end else if (part_stb && (mode_q == MD_TC)) begin
        run_q   <= 1'b0;
        tmr_out <= 1'b0;
      end else if (step) begin
        case (mode_q)
          MD_RATE: begin
            if (cnt_q == ONE) begin
              cnt_q   <= reload_q;
              tmr_out <= 1'b1;
            end else begin
              cnt_q <= dec;
              if (dec == ONE) tmr_out <= 1'b0;
            end
          end
          MD_STROBE: begin
            cnt_q   <= dec;
            tmr_out <= !hit0;
            if (hit0) armed_q <= 1'b0;
          end
          default: begin
            cnt_q <= dec;
            if (hit0) begin
              tmr_out <= 1'b1;
              armed_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ivt_chan.sv
module ivt_chan
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             cnt_en,
  output logic             tmr_out
);

  logic             ctl_wr;
  logic             dat_wr;
  logic             dat_rd;
  logic             ctl_rd;
  ivt_mode_e        mode_q;
  ivt_mode_e        new_mode;
  ivt_acc_e         acc_q;
  logic             mode_set;
  logic             snap_cmd;
  logic             load_stb;
  logic             part_stb;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             latched_q;
  logic [CNT_W-1:0] snap_q;

  assign ctl_wr = bus_wr && bus_addr;
  assign dat_wr = bus_wr && !bus_addr;
  assign dat_rd = bus_rd && !bus_wr && !bus_addr;
  assign ctl_rd = bus_rd && !bus_wr && bus_addr;

  ivt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .wdata    (bus_wdata),
    .mode_q   (mode_q),
    .new_mode (new_mode),
    .acc_q    (acc_q),
    .mode_set (mode_set),
    .snap_cmd (snap_cmd)
  );

  ivt_io #(.CNT_W(CNT_W)) u_io (
    .clk       (clk),
    .rst       (rst),
    .acc_q     (acc_q),
    .mode_set  (mode_set),
    .snap_cmd  (snap_cmd),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .ctl_rd    (ctl_rd),
    .wdata     (bus_wdata),
    .cnt_q     (cnt_q),
    .load_stb  (load_stb),
    .part_stb  (part_stb),
    .load_val  (load_val),
    .rdata     (bus_rdata),
    .latched_q (latched_q),
    .snap_q    (snap_q)
  );

  ivt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .mode_q   (mode_q),
    .new_mode (new_mode),
    .mode_set (mode_set),
    .load_stb (load_stb),
    .part_stb (part_stb),
    .load_val (load_val),
    .cnt_q    (cnt_q),
    .tmr_out  (tmr_out)
  );

endmodule

// File: rtl/ivt_chan_chk.sv
module ivt_chan_chk
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             cnt_en,
  input logic             tmr_out,
  input ivt_mode_e        mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             latched_q,
  input logic [CNT_W-1:0] snap_q
);

  logic en_prev;

  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b1;
    else     en_prev <= cnt_en;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tmr_out && (bus_rdata == '0)));

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(cnt_en && !en_prev) && !bus_wr) |=> $stable(cnt_q));

  // R8
  tc_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == MD_TC) && tmr_out && !bus_wr) |=> tmr_out);

  // R9
  rate_low_at_one_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == MD_RATE) && !tmr_out) |-> (cnt_q == CNT_W'(1)));

  // R11
  strobe_low_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == MD_STROBE) && !tmr_out) |-> (cnt_q == '0));

  // R12
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latched_q && !bus_rd && !bus_wr) |=> (latched_q && $stable(snap_q)));

endmodule

bind ivt_chan ivt_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .cnt_en    (cnt_en),
  .tmr_out   (tmr_out),
  .mode_q    (mode_q),
  .cnt_q     (cnt_q),
  .latched_q (latched_q),
  .snap_q    (snap_q)
);

// File: tb/sim_ivt_chan.sv
module sim_ivt_chan;

  localparam int CW   = 10;
  localparam int FULL = 1 << CW;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cnt_en = 1'b0;
  logic       tmr_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ivt_chan #(.CNT_W(CW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_en    (cnt_en),
    .tmr_out   (tmr_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input int d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d[7:0];
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output int d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  task automatic wr_cnt(input int v);
    wr(1'b0, v & 255);
    wr(1'b0, (v >> 8) & 255);
  endtask

  // snapshot then two-byte read (low-then-high access)
  task automatic rd_cnt(output int v);
    int lo;
    int hi;
    wr(1'b1, 8'h00);
    rd(1'b0, lo);
    rd(1'b0, hi);
    v = lo | (hi << 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int lo;
    int hi;
    int bad;
    int tc_list[17] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 255, 256, 257, 600, 1023};
    int rate_list[4] = '{2, 3, 5, 7};
    int bad_cw[5] = '{8'h70, 8'h31, 8'h32, 8'h36, 8'hB0};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 tmr_out after reset", int'(tmr_out), 0);
    chk("R1 rdata after reset", int'(bus_rdata), 0);
    rd(1'b0, lo);
    rd(1'b0, hi);
    chk("R1 R13 live count after reset", lo | (hi << 8), 0);

    // R8 terminal-count sweep, R12 mid-run snapshot
    foreach (tc_list[k]) begin
      int n = tc_list[k];
      wr(1'b1, 8'h30);
      wr_cnt(n);
      chk("R8 out low after load", int'(tmr_out), 0);
      if (n >= 4) begin
        pulse(n / 2);
        rd_cnt(v);
        chk("R12 R7 mid-run snapshot", v, n - n / 2);
        pulse(n - n / 2 - 1);
      end else begin
        pulse(n - 1);
      end
      chk("R8 out low one edge before expiry", int'(tmr_out), 0);
      pulse(1);
      chk("R8 out high at expiry", int'(tmr_out), 1);
      rd_cnt(v);
      chk("R8 count at expiry", v, 0);
    end

    // R8 stays high, counter wraps
    pulse(3);
    chk("R8 out stays high", int'(tmr_out), 1);
    rd_cnt(v);
    chk("R8 R7 wrapped count", v, FULL - 3);

    // R6 zero count and R8 rearm after stop
    wr(1'b1, 8'h30);
    wr_cnt(0);
    chk("R8 zero count rearms low", int'(tmr_out), 0);
    pulse(FULL - 1);
    chk("R6 low before full range", int'(tmr_out), 0);
    pulse(1);
    chk("R6 high after full range", int'(tmr_out), 1);

    // R4 low byte halts terminal-count
    wr(1'b1, 8'h30);
    wr_cnt(10);
    pulse(3);
    wr(1'b0, 5);
    chk("R4 low byte drives out low", int'(tmr_out), 0);
    pulse(4);
    rd_cnt(v);
    chk("R4 count halted after low byte", v, 7);
    wr(1'b0, 0);
    pulse(4);
    chk("R4 new count running", int'(tmr_out), 0);
    pulse(1);
    chk("R4 new count expires", int'(tmr_out), 1);

    // R3 pointer reset and stop
    wr(1'b1, 8'h30);
    wr(1'b0, 5);
    wr(1'b1, 8'h30);
    wr_cnt(7);
    pulse(6);
    chk("R3 pointer reset count not expired", int'(tmr_out), 0);
    pulse(1);
    chk("R3 pointer reset count expired", int'(tmr_out), 1);
    wr(1'b1, 8'h30);
    wr_cnt(50);
    pulse(3);
    wr(1'b1, 8'h34);
    chk("R3 rate word sets out high", int'(tmr_out), 1);
    pulse(5);
    rd_cnt(v);
    chk("R3 control word stops count", v, 47);

    // R9 rate generator sweep
    foreach (rate_list[k]) begin
      int n = rate_list[k];
      wr(1'b1, 8'h34);
      wr_cnt(n);
      chk("R9 out high after load", int'(tmr_out), 1);
      for (int e = 1; e <= 3 * n; e++) begin
        pulse(1);
        chk("R9 periodic output", int'(tmr_out), ((e % n) == n - 1) ? 0 : 1);
      end
    end
    wr(1'b1, 8'h3C);
    wr_cnt(3);
    for (int e = 1; e <= 6; e++) begin
      pulse(1);
      chk("R2 R9 code 110 periodic", int'(tmr_out), ((e % 3) == 2) ? 0 : 1);
    end
    wr(1'b1, 8'h34);
    wr_cnt(5);
    pulse(7);
    rd_cnt(v);
    chk("R9 reload count value", v, 3);
    wr(1'b1, 8'h34);
    wr_cnt(0);
    pulse(FULL - 2);
    chk("R6 R9 zero count high", int'(tmr_out), 1);
    pulse(1);
    chk("R6 R9 zero count low at one", int'(tmr_out), 0);
    pulse(1);
    chk("R6 R9 zero count reload", int'(tmr_out), 1);

    // R10 deferred reload
    wr(1'b1, 8'h34);
    wr_cnt(4);
    pulse(1);
    wr_cnt(6);
    pulse(1);
    chk("R10 old pass continues", int'(tmr_out), 1);
    pulse(1);
    chk("R10 old pass low at one", int'(tmr_out), 0);
    pulse(1);
    chk("R10 reload high", int'(tmr_out), 1);
    pulse(4);
    chk("R10 new period not yet low", int'(tmr_out), 1);
    pulse(1);
    chk("R10 new period low", int'(tmr_out), 0);

    // R11 strobe
    wr(1'b1, 8'h38);
    chk("R3 R11 strobe word sets out high", int'(tmr_out), 1);
    wr_cnt(6);
    chk("R11 out high after load", int'(tmr_out), 1);
    pulse(5);
    chk("R11 high before strobe", int'(tmr_out), 1);
    pulse(1);
    chk("R11 strobe low", int'(tmr_out), 0);
    pulse(1);
    chk("R11 strobe ends", int'(tmr_out), 1);
    bad = 0;
    for (int e = 0; e < 10; e++) begin
      pulse(1);
      if (!tmr_out) bad++;
    end
    chk("R11 no second strobe", bad, 0);
    rd_cnt(v);
    chk("R11 counter keeps wrapping", v, FULL - 11);
    wr_cnt(3);
    chk("R11 retrigger out high", int'(tmr_out), 1);
    pulse(2);
    chk("R11 retrigger before strobe", int'(tmr_out), 1);
    pulse(1);
    chk("R11 retrigger strobe", int'(tmr_out), 0);
    pulse(1);
    chk("R11 retrigger strobe ends", int'(tmr_out), 1);

    // R2 ignored control words
    wr(1'b1, 8'h30);
    wr_cnt(2);
    pulse(2);
    foreach (bad_cw[k]) begin
      wr(1'b1, bad_cw[k]);
      chk("R2 ignored word keeps out", int'(tmr_out), 1);
    end
    wr_cnt(3);
    chk("R2 mode unchanged after ignored words", int'(tmr_out), 0);
    pulse(3);
    chk("R2 terminal count still active", int'(tmr_out), 1);

    // R12 snapshot hold and second command ignored
    wr(1'b1, 8'h30);
    wr_cnt(500);
    pulse(10);
    wr(1'b1, 8'h00);
    chk("R12 snapshot leaves out", int'(tmr_out), 0);
    pulse(5);
    rd(1'b0, lo);
    chk("R12 snapshot low byte", lo, 490 & 255);
    pulse(3);
    wr(1'b1, 8'h00);
    rd(1'b0, hi);
    chk("R12 snapshot high byte", hi, 490 >> 8);
    rd_cnt(v);
    chk("R12 new snapshot after release", v, 482);

    // R13 live reads and control read
    wr(1'b1, 8'h30);
    wr_cnt(300);
    pulse(7);
    rd(1'b0, lo);
    chk("R13 live low byte", lo, 293 & 255);
    rd(1'b0, hi);
    chk("R13 live high byte", hi, 293 >> 8);
    rd(1'b1, v);
    chk("R13 control read is zero", v, 0);

    // R5 single-byte access schemes
    wr(1'b1, 8'h10);
    wr(1'b0, 9);
    chk("R5 low-only load out low", int'(tmr_out), 0);
    pulse(8);
    chk("R5 low-only not expired", int'(tmr_out), 0);
    pulse(1);
    chk("R5 low-only expired", int'(tmr_out), 1);
    pulse(1);
    rd(1'b0, v);
    chk("R5 low-only read", v, (FULL - 1) & 255);
    wr(1'b1, 8'h20);
    wr(1'b0, 8'hFD);
    pulse(255);
    chk("R5 high-only not expired", int'(tmr_out), 0);
    pulse(1);
    chk("R5 high-only expires at 256", int'(tmr_out), 1);
    pulse(1);
    rd(1'b0, v);
    chk("R5 high-only read", v, (FULL - 1) >> 8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule